// File: doc/BRIEF.md
# HDLC Serial Frame Receiver

This block takes a bit-serial HDLC line and turns it into bytes for a receive queue. It looks for the flag octet to find where packets start and end. It removes the zeros that the sender inserted after runs of five ones, and it collects the remaining bits into bytes, least significant bit first. It runs a 16-bit frame check over every byte, including the two check bytes at the end. Each payload byte goes out on a one-cycle write strobe as a 10-bit entry. The top two bits of the entry tell the reader whether the byte opens the packet, sits in the middle, or closes it. A closing byte is marked as closing with a good check, or as closing with a bad check or an abort.

The line is sampled only on cycles where the bit enable is high, so the block can sit on a fast core clock while a slower serial clock feeds it. A run of fifteen or more ones raises a level idle indication. A zero, seven ones and then a zero, whose leading zero falls outside any packet, gives a one-cycle go-ahead pulse. The two check bytes never reach the queue. Packets too short to hold a check are dropped without a trace.

Top module: `hdlc_frame_rx`

## Requirements
- R1: While hunting, the receiver ignores every bit until the flag pattern arrives: a zero, six ones, then a zero (octet 0x7E). The flag opens a packet, and any later flag closes the current packet and opens the next.
- R2: Inside a packet, a zero that follows five consecutive ones is discarded and takes no part in the data bytes.
- R3: Data bits are packed least significant bit first. Each entry is written as fifo_data[9:8] = status and fifo_data[7:0] = byte, with status 01 for the first byte of a packet and 00 for each middle byte.
- R4: At the closing flag, the last payload byte is written with status 10 when the check residue equals 0xF0B8. The check is CRC-16 with reversed polynomial 0x8408, preset 0xFFFF, and covers all bytes including the check; the sender transmits the complemented CRC low byte first. The two check bytes are never written.
- R5: At the closing flag, the last payload byte is written with status 11 when the residue is wrong or the flag does not fall on a byte boundary.
- R6: A closing flag that arrives after fewer than 32 payload-plus-check bits produces no entry at all. A packet of exactly 32 such bits is delivered.
- R7: Seven consecutive ones inside a packet that has already gathered at least 26 data bits form an abort. The abort writes one entry with status 11 and returns the receiver to hunting. Data ones at the tail of the last byte count toward the seven.
- R8: Seven consecutive ones inside a packet with fewer than 26 data bits drop the packet silently and return the receiver to hunting.
- R9: idle goes high once fifteen consecutive ones have been sampled, not after fourteen, and goes low on the next sampled zero.
- R10: go_ahead pulses for one cycle when a zero follows exactly seven ones whose leading zero was outside a packet (while hunting, or the closing zero of a flag). It does not pulse after an in-packet abort.
- R11: Bits are taken only when bit_en is high. While rx_en is low the receiver is held in its reset state (hunting, no writes, idle and go_ahead low). All outputs are low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Receiver enable; low holds the receiver cleared |
| bit_en | input | 1 | Sample strobe; rx_bit is taken on cycles where it is high |
| rx_bit | input | 1 | Serial line data |
| fifo_wr | output | 1 | One-cycle write strobe for the receive queue |
| fifo_data | output | 10 | Queue entry: status in [9:8], byte in [7:0] |
| idle | output | 1 | High while fifteen or more consecutive ones have been seen |
| go_ahead | output | 1 | One-cycle pulse on a go-ahead pattern outside a packet |

## Verification
The bench builds the block with its default values: an idle threshold of fifteen ones and an abort threshold of 26 data bits. With these values the idle boundary falls between the fourteenth and fifteenth one of a short run. A one-byte packet sits below the abort threshold and a four-byte packet sits above it, so the silent drop and the reported abort both show up within a few dozen bits. The fixed three-byte holdback places the short-frame limit exactly between a one-byte and a two-byte payload, so both sides of that boundary are driven. Every line bit is followed by a gap cycle that carries the inverted bit with the strobe low.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;

    localparam int BYTE_W    = 8;
    localparam int STAT_W    = 2;
    localparam int ENTRY_W   = STAT_W + BYTE_W;
    localparam int FCS_BYTES = 2;

    localparam logic [15:0] CRC_PRESET   = 16'hFFFF;
    localparam logic [15:0] CRC_POLY_REV = 16'h8408;
    localparam logic [15:0] CRC_GOOD_RES = 16'hF0B8;

    typedef enum logic [STAT_W-1:0] {
        STAT_MID     = 2'b00,
        STAT_FIRST   = 2'b01,
        STAT_END_OK  = 2'b10,
        STAT_END_BAD = 2'b11
    } entry_stat_e;

    typedef enum logic {
        RX_HUNT,
        RX_OPEN
    } rx_mode_e;

    // One byte through the reflected CRC-16, least significant bit first.
    function automatic logic [15:0] crc16_byte(input logic [15:0] c,
                                               input logic [BYTE_W-1:0] d);
        logic [15:0] r;
        r = c;
        for (int i = 0; i < BYTE_W; i++) begin
            if (r[0] ^ d[i]) r = (r >> 1) ^ CRC_POLY_REV;
            else             r = r >> 1;
        end
        return r;
    endfunction

endpackage

// File: rtl/hdlc_run_classifier.sv
// Tracks the run of consecutive ones on the line and classifies each
// sampled bit: data, stuffed zero, flag, seventh one; also idle and go-ahead.
module hdlc_run_classifier #(
    parameter int IDLE_RUN = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_en,
    input  logic take,
    input  logic din,
    input  logic hunting,
    output logic is_data,
    output logic is_flag,
    output logic is_seventh,
    output logic idle,
    output logic go_ahead
);

    localparam int RUN_W = $clog2(IDLE_RUN + 1);
    localparam logic [RUN_W-1:0] RUN_STUFF = RUN_W'(5);
    localparam logic [RUN_W-1:0] RUN_FLAG  = RUN_W'(6);
    localparam logic [RUN_W-1:0] RUN_GA    = RUN_W'(7);
    localparam logic [RUN_W-1:0] RUN_SAT   = RUN_W'(IDLE_RUN);
    localparam logic [RUN_W-1:0] RUN_PRE   = RUN_W'(IDLE_RUN - 1);

    typedef struct packed {
        logic [RUN_W-1:0] run;
        logic             outside;
        logic             idle;
        logic             ga;
    } cls_t;

    localparam cls_t CLS_RST = '{run: '0, outside: 1'b1, idle: 1'b0, ga: 1'b0};

    cls_t cls_d, cls_q;

    assign is_data    = take && (cls_q.run < RUN_STUFF);
    assign is_flag    = take && !din && (cls_q.run == RUN_FLAG);
    assign is_seventh = take &&  din && (cls_q.run == RUN_FLAG);
    assign idle       = cls_q.idle;
    assign go_ahead   = cls_q.ga;

    always_comb begin
        cls_d    = cls_q;
        cls_d.ga = 1'b0;
        if (!rx_en) begin
            cls_d = CLS_RST;
        end else if (take) begin
            if (din) begin
                if (cls_q.run != RUN_SAT) cls_d.run = cls_q.run + 1'b1;
                cls_d.idle = (cls_q.run >= RUN_PRE);
            end else begin
                cls_d.run     = '0;
                cls_d.idle    = 1'b0;
                cls_d.ga      = (cls_q.run == RUN_GA) && cls_q.outside;
                cls_d.outside = hunting || (cls_q.run == RUN_FLAG);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cls_q <= CLS_RST;
        else        cls_q <= cls_d;
    end

endmodule

// File: rtl/hdlc_fcs16.sv
// Byte-wise CRC-16 accumulator over received bytes.
module hdlc_fcs16 (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        step,
    input  logic [7:0]  byte_in,
    output logic [15:0] crc
);
    import hdlc_rx_pkg::*;

    logic [15:0] crc_d, crc_q;

    assign crc = crc_q;

    always_comb begin
        crc_d = crc_q;
        if (clr)       crc_d = CRC_PRESET;
        else if (step) crc_d = crc16_byte(crc_q, byte_in);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) crc_q <= CRC_PRESET;
        else        crc_q <= crc_d;
    end

endmodule

// File: rtl/hdlc_byte_holdback.sv
// Delay line of completed bytes; the oldest is released only once it is
// known not to be part of the trailing check bytes.
module hdlc_byte_holdback #(
    parameter int DEPTH = 3,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         push,
    input  logic [W-1:0] din,
    output logic         full,
    output logic [W-1:0] oldest
);

    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [CNT_W-1:0]        cnt;
    } hb_t;

    hb_t hb_d, hb_q;

    assign full   = (hb_q.cnt == CNT_FULL);
    assign oldest = hb_q.mem[0];

    always_comb begin
        hb_d = hb_q;
        if (clr) begin
            hb_d.cnt = '0;
        end else if (push) begin
            for (int i = 0; i < DEPTH - 1; i++) hb_d.mem[i] = hb_q.mem[i+1];
            hb_d.mem[DEPTH-1] = din;
            if (hb_q.cnt != CNT_FULL) hb_d.cnt = hb_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hb_q <= '0;
        else        hb_q <= hb_d;
    end

endmodule

// File: rtl/hdlc_frame_rx.sv
module hdlc_frame_rx #(
    parameter int IDLE_RUN       = 15,
    parameter int ABORT_MIN_BITS = 26
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_en,
    input  logic       bit_en,
    input  logic       rx_bit,
    output logic       fifo_wr,
    output logic [9:0] fifo_data,
    output logic       idle,
    output logic       go_ahead
);
    import hdlc_rx_pkg::*;

    localparam int HOLD_DEPTH = FCS_BYTES + 1;
    localparam int NB_W       = $clog2(ABORT_MIN_BITS + 1);
    localparam logic [NB_W-1:0] NB_SAT = NB_W'(ABORT_MIN_BITS);
    localparam int BC_W       = $clog2(BYTE_W);
    localparam logic [BC_W-1:0] BC_LAST = BC_W'(BYTE_W - 1);
    localparam logic [BC_W-1:0] BC_FLAG = BC_W'(6);

    typedef struct packed {
        rx_mode_e            mode;
        logic [BYTE_W-2:0]   sh;
        logic [BC_W-1:0]     bcnt;
        logic [NB_W-1:0]     nbits;
        logic                started;
        logic                wr;
        logic [ENTRY_W-1:0]  wdata;
    } rx_t;

    localparam rx_t RX_RST = '{mode: RX_HUNT, sh: '0, bcnt: '0, nbits: '0,
                               started: 1'b0, wr: 1'b0, wdata: '0};

    rx_t rx_d, rx_q;

    logic              take;
    logic              is_data, is_flag, is_seventh;
    logic              open_pkt, byte_done, seq_clr;
    logic [BYTE_W-1:0] new_byte, held;
    logic              hold_full;
    logic [15:0]       crc;

    assign take      = rx_en && bit_en;
    assign open_pkt  = (rx_q.mode == RX_OPEN);
    assign new_byte  = {rx_bit, rx_q.sh};
    assign byte_done = open_pkt && is_data && (rx_q.bcnt == BC_LAST);
    assign seq_clr   = !rx_en || is_flag || is_seventh;

    hdlc_run_classifier #(.IDLE_RUN(IDLE_RUN)) u_cls (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_en      (rx_en),
        .take       (take),
        .din        (rx_bit),
        .hunting    (!open_pkt),
        .is_data    (is_data),
        .is_flag    (is_flag),
        .is_seventh (is_seventh),
        .idle       (idle),
        .go_ahead   (go_ahead)
    );

    hdlc_fcs16 u_fcs (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (seq_clr),
        .step    (byte_done),
        .byte_in (new_byte),
        .crc     (crc)
    );

    hdlc_byte_holdback #(.DEPTH(HOLD_DEPTH), .W(BYTE_W)) u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (seq_clr),
        .push   (byte_done),
        .din    (new_byte),
        .full   (hold_full),
        .oldest (held)
    );

    always_comb begin
        rx_d    = rx_q;
        rx_d.wr = 1'b0;
        if (!rx_en) begin
            rx_d = RX_RST;
        end else begin
            // Payload bit: shift in, count, release a byte once safe.
            if (open_pkt && is_data) begin
                rx_d.sh   = {rx_bit, rx_q.sh[BYTE_W-2:1]};
                rx_d.bcnt = rx_q.bcnt + 1'b1;
                if (rx_q.nbits != NB_SAT) rx_d.nbits = rx_q.nbits + 1'b1;
                if (byte_done && hold_full) begin
                    rx_d.wr      = 1'b1;
                    rx_d.wdata   = {rx_q.started ? STAT_MID : STAT_FIRST, held};
                    rx_d.started = 1'b1;
                end
            end
            // Flag: close the current packet (if long enough), open the next.
            if (is_flag) begin
                if (open_pkt && rx_q.started) begin
                    rx_d.wr    = 1'b1;
                    rx_d.wdata = {((rx_q.bcnt == BC_FLAG) && (crc == CRC_GOOD_RES))
                                  ? STAT_END_OK : STAT_END_BAD, held};
                end
                rx_d.mode    = RX_OPEN;
                rx_d.bcnt    = '0;
                rx_d.nbits   = '0;
                rx_d.started = 1'b0;
            end
            // Seventh one: abort when the packet is long enough, else drop.
            if (is_seventh && open_pkt) begin
                if (rx_q.nbits == NB_SAT) begin
                    rx_d.wr    = 1'b1;
                    rx_d.wdata = {STAT_END_BAD, held};
                end
                rx_d.mode    = RX_HUNT;
                rx_d.bcnt    = '0;
                rx_d.nbits   = '0;
                rx_d.started = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rx_q <= RX_RST;
        else        rx_q <= rx_d;
    end

    assign fifo_wr   = rx_q.wr;
    assign fifo_data = rx_q.wdata;

endmodule

// File: rtl/hdlc_frame_rx_chk.sv
module hdlc_frame_rx_chk (
    input logic clk,
    input logic rst_n,
    input logic rx_en,
    input logic bit_en,
    input logic rx_bit,
    input logic fifo_wr,
    input logic idle,
    input logic go_ahead
);

    // R11
    wr_after_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_wr |-> $past(bit_en && rx_en));

    // R11
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> (!fifo_wr && !idle && !go_ahead));

    // R10
    ga_on_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        go_ahead |-> ($past(bit_en && rx_en) && !$past(rx_bit)));

    // R10
    ga_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        go_ahead |-> !fifo_wr);

    // R9
    idle_rise_on_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(idle) |-> ($past(bit_en) && $past(rx_bit)));

    // R9
    idle_clear_on_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bit_en && rx_en && !rx_bit) |-> !idle);

endmodule

bind hdlc_frame_rx hdlc_frame_rx_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_en    (rx_en),
    .bit_en   (bit_en),
    .rx_bit   (rx_bit),
    .fifo_wr  (fifo_wr),
    .idle     (idle),
    .go_ahead (go_ahead)
);

// File: tb/sim_hdlc_frame_rx.sv
module sim_hdlc_frame_rx;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_en = 1'b0;
    logic       bit_en = 1'b0;
    logic       rx_bit = 1'b0;
    logic       fifo_wr;
    logic [9:0] fifo_data;
    logic       idle;
    logic       go_ahead;

    always #5 clk = ~clk;

    hdlc_frame_rx u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_en     (rx_en),
        .bit_en    (bit_en),
        .rx_bit    (rx_bit),
        .fifo_wr   (fifo_wr),
        .fifo_data (fifo_data),
        .idle      (idle),
        .go_ahead  (go_ahead)
    );

    int         n_chk = 0;
    int         n_fail = 0;
    int         tx_ones = 0;
    bit         done = 1'b0;
    logic [9:0] exp_q[$];
    string      tag_q[$];
    logic [7:0] pay[$];

    // Monitor: every write must match the head of the scoreboard.
    always @(negedge clk) begin
        logic [9:0] e;
        string      t;
        if (rst_n && fifo_wr) begin
            n_chk++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL R6/R8/R11: unexpected write %h, expected none", fifo_data);
            end else begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (fifo_data !== e) begin
                    n_fail++;
                    $display("FAIL %s: fifo_data=%h expected %h", t, fifo_data, e);
                end
            end
        end
    end

    task automatic expect_entry(input logic [1:0] st, input logic [7:0] b, input string tag);
        exp_q.push_back({st, b});
        tag_q.push_back(tag);
    endtask

    // One line bit, then a gap cycle with the strobe low and the bit inverted.
    task automatic send_raw(input logic b);
        @(negedge clk);
        rx_bit = b;
        bit_en = 1'b1;
        @(negedge clk);
        bit_en = 1'b0;
        rx_bit = ~b;
    endtask

    task automatic send_dbit(input logic b);
        send_raw(b);
        if (b) begin
            tx_ones++;
            if (tx_ones == 5) begin
                send_raw(1'b0);
                tx_ones = 0;
            end
        end else begin
            tx_ones = 0;
        end
    endtask

    task automatic send_dbyte(input logic [7:0] v);
        for (int i = 0; i < 8; i++) send_dbit(v[i]);
    endtask

    task automatic send_flag();
        send_raw(1'b0);
        for (int i = 0; i < 6; i++) send_raw(1'b1);
        send_raw(1'b0);
        tx_ones = 0;
    endtask

    function automatic logic [15:0] crc_upd(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r;
        r = c;
        for (int i = 0; i < 8; i++) begin
            if (r[0] ^ d[i]) r = (r >> 1) ^ 16'h8408;
            else             r = r >> 1;
        end
        return r;
    endfunction

    // Sends flag, pay[], check bytes, flag; queues the expected entries.
    task automatic send_frame(input logic bad, input logic want, input string tag);
        logic [15:0] c;
        int          n;
        n = pay.size();
        c = 16'hFFFF;
        if (want && (n + 2 >= 4)) begin
            for (int i = 0; i < n; i++) begin
                if (i == 0)          expect_entry(2'b01, pay[i], tag);
                else if (i == n - 1) expect_entry(bad ? 2'b11 : 2'b10, pay[i], tag);
                else                 expect_entry(2'b00, pay[i], tag);
            end
        end
        send_flag();
        for (int i = 0; i < n; i++) begin
            c = crc_upd(c, pay[i]);
            send_dbyte(pay[i]);
        end
        c = ~c;
        if (bad) c = c ^ 16'h0001;
        send_dbyte(c[7:0]);
        send_dbyte(c[15:8]);
        send_flag();
    endtask

    task automatic check_drained(input string tag);
        @(negedge clk);
        @(negedge clk);
        n_chk++;
        if (exp_q.size() != 0) begin
            n_fail++;
            $display("FAIL %s: %0d entries missing, expected 0", tag, exp_q.size());
        end
        exp_q.delete();
        tag_q.delete();
    endtask

    task automatic chk_bit(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk_bit("R11 reset fifo_wr", fifo_wr, 1'b0);
        chk_bit("R11 reset idle", idle, 1'b0);
        chk_bit("R11 reset go_ahead", go_ahead, 1'b0);
        rx_en = 1'b1;

        // R9 idle threshold: fourteen ones no, fifteen yes, zero clears
        for (int i = 0; i < 14; i++) send_raw(1'b1);
        chk_bit("R9 idle after 14 ones", idle, 1'b0);
        send_raw(1'b1);
        chk_bit("R9 idle after 15 ones", idle, 1'b1);
        send_raw(1'b1);
        send_raw(1'b0);
        chk_bit("R9 idle cleared by zero", idle, 1'b0);
        chk_bit("R10 no go-ahead after long run", go_ahead, 1'b0);

        // R1 noise while hunting, R2 stuffing, R3/R4 good frame
        send_raw(1'b1); send_raw(1'b0); send_raw(1'b1); send_raw(1'b1); send_raw(1'b0);
        pay = '{8'h12, 8'hFF, 8'h7E, 8'h01};
        send_frame(1'b0, 1'b1, "R1 R2 R3 R4 good frame");
        check_drained("R4 good frame complete");

        // R5 corrupted check
        pay = '{8'hA5, 8'h3C, 8'h99};
        send_frame(1'b1, 1'b1, "R5 bad check");
        check_drained("R5 bad check complete");

        // R6 short frame: 24 bits, nothing written
        pay = '{8'h55};
        send_frame(1'b0, 1'b1, "R6 short");
        check_drained("R6 short frame silent");

        // R6 boundary: exactly 32 bits delivered
        pay = '{8'h81, 8'h42};
        send_frame(1'b0, 1'b1, "R6 minimum frame");
        check_drained("R6 minimum frame complete");

        // R7 abort with trailing ones of the last byte counted
        expect_entry(2'b01, 8'h11, "R7 abort first");
        expect_entry(2'b11, 8'h22, "R7 abort entry");
        send_flag();
        send_dbyte(8'h11); send_dbyte(8'h22); send_dbyte(8'h33); send_dbyte(8'hE0);
        for (int i = 0; i < 4; i++) send_raw(1'b1);
        check_drained("R7 abort written");
        send_raw(1'b0);
        chk_bit("R10 no go-ahead after in-packet abort", go_ahead, 1'b0);

        // R8 short abort dropped
        send_flag();
        send_dbyte(8'h0F);
        for (int i = 0; i < 7; i++) send_raw(1'b1);
        send_raw(1'b0);
        check_drained("R8 short abort silent");

        // R10 go-ahead outside a packet
        send_raw(1'b0);
        for (int i = 0; i < 7; i++) send_raw(1'b1);
        send_raw(1'b0);
        chk_bit("R10 go-ahead pulse", go_ahead, 1'b1);
        send_raw(1'b0);
        chk_bit("R10 go-ahead one cycle", go_ahead, 1'b0);

        // R11 disabled receiver ignores everything
        rx_en = 1'b0;
        for (int i = 0; i < 16; i++) send_raw(1'b1);
        chk_bit("R11 idle held low when disabled", idle, 1'b0);
        pay = '{8'h33, 8'h44};
        send_frame(1'b0, 1'b0, "R11 disabled");
        check_drained("R11 disabled no writes");
        rx_en = 1'b1;

        // R11 recovery with gated strobe between every bit
        pay = '{8'hC3, 8'h3C, 8'h00};
        send_frame(1'b0, 1'b1, "R11 gated frame");
        check_drained("R11 gated frame complete");

        done = 1'b1;
        summary();
        $finish;
    end

endmodule